// File: doc/BRIEF.md
# Pseudorandom Self-Test Controller

This block wraps a small circuit under test, for example a serial datapath in loopback, with a built-in self-test. In normal operation the circuit's inputs come straight from their functional source. When the mode pin selects test, a sequencer takes over:

- it points the input multiplexer at an 8-bit linear feedback shift register;
- it steps that register through a fixed number of pseudorandom patterns;
- it checks every response the circuit returns;
- at the end it raises a done flag and a single go/no-go verdict.

A small control/status word lets software restart the test and read progress and outcome. All pins are plain level signals sampled on every clock edge. There is no valid/ready handshake and so no back-pressure: the circuit under test must accept a new input word on any cycle, and must return its response with at most one cycle of latency.

The expected response is the applied pattern itself, which is the loopback case. Each pattern is held for two cycles, one to apply it and one to compare. A loopback with one register stage is therefore checked correctly.

Top module: `bist_ctrl`

## Requirements
- R1: While `test_mode` is 0, `cut_in` equals `func_in` in every cycle.
- R2: A test starts when the controller is idle or finished and either `test_mode` rises, or a write with `cfg_wdata[0]`=1 arrives while `test_mode` is 1. `busy` is 1 from the cycle after that edge. A start request while busy, or a register start while `test_mode` is 0, is ignored.
- R3: While `test_mode` is 1, `cut_in` carries the pattern register's current value.
- R4: At test start the pattern register is loaded with 0x01. After each compared pattern it advances as next = {q[6:0], q[7]^q[5]^q[4]^q[3]}, which is the polynomial x^8+x^6+x^5+x^4+1. It never holds zero.
- R5: Each pattern is held for two cycles, an apply cycle and a compare cycle. In the compare cycle `cut_out` must equal the pattern. A full test takes 2*NUM_PAT+2 clock edges from the start edge to `done`.
- R6: After NUM_PAT patterns the controller sets `done` and clears `busy`. With the default of 255, every nonzero 8-bit value is applied exactly once.
- R7: A single mismatch makes the verdict fail. `go_nogo` is 1 only while `done` is 1 and no mismatch was seen. The verdict and `done` hold, even after `test_mode` falls, until the next start.
- R8: `cfg_rdata` reads bit0 = 0 (the start bit is write-only), bit1 = busy, bit2 = done, bit3 = pass. After reset it reads 0.
- R9: Dropping `test_mode` while busy aborts the test. The next cycle shows `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 selects self-test, 0 selects the functional path |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 4 | Control word; bit0 requests a start |
| cfg_rdata | output | 4 | Status word: pass, done, busy, 0 |
| func_in | input | W | Functional input for the circuit under test |
| cut_in | output | W | Input driven into the circuit under test |
| cut_out | input | W | Response of the circuit under test |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished |
| go_nogo | output | 1 | 1 = test passed (meaningful while done) |

## Verification
The bench runs a behavioural model alongside the design and compares it with the design in every cycle. Its corner cases are these:

- **Pattern set.** A full run must apply each nonzero byte exactly once. A wrong tap or seed would repeat values or reach zero, and the distinctness count would expose it.
- **Fault latching.** A single flipped bit is injected on one pattern, and the run must end in no-go. A comparator that forgets the mismatch would report pass.
- **Late starts.** Start requests arrive in the middle of a run and while test mode is off. A controller that honours them would restart or leave idle.
- **Abort.** Test mode is dropped in the middle of a run. A missing abort path would keep `busy` high or go on to report `done`.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int STAT_W = 4;
  localparam int STAT_START = 0;
  localparam int STAT_BUSY  = 1;
  localparam int STAT_DONE  = 2;
  localparam int STAT_PASS  = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_APPLY = 3'd2,
    ST_CMP   = 3'd3,
    ST_DONE  = 3'd4
  } bist_state_e;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SEED;
    else if (load) q <= SEED;
    else if (step) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/bist_cmp.sv
module bist_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] resp,
  input  logic [W-1:0] expect_val,
  output logic         fail
);
  logic mismatch;
  assign mismatch = en && (resp != expect_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fail <= 1'b0;
    else if (clr)      fail <= 1'b0;
    else if (mismatch) fail <= 1'b1;
  end
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import bist_pkg::*;
#(
  parameter int NUM_PAT = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        test_mode,
  output bist_state_e state,
  output logic        lfsr_load,
  output logic        lfsr_step,
  output logic        cmp_en,
  output logic        clr_fail
);
  localparam int CW = $clog2(NUM_PAT + 1);
  localparam logic [CW-1:0] LAST = CW'(NUM_PAT - 1);

  bist_state_e nxt;
  logic [CW-1:0] cnt;

  assign lfsr_load = (state == ST_INIT) && test_mode;
  assign clr_fail  = lfsr_load;
  assign cmp_en    = (state == ST_CMP) && test_mode;
  assign lfsr_step = cmp_en;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE, ST_DONE: if (start_req) nxt = ST_INIT;
      ST_INIT:  nxt = test_mode ? ST_APPLY : ST_IDLE;
      ST_APPLY: nxt = test_mode ? ST_CMP : ST_IDLE;
      ST_CMP: begin
        if (!test_mode)       nxt = ST_IDLE;
        else if (cnt == LAST) nxt = ST_DONE;
        else                  nxt = ST_APPLY;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (lfsr_load)   cnt <= '0;
      else if (cmp_en) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01,
  parameter int NUM_PAT = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              cfg_wr,
  input  logic [STAT_W-1:0] cfg_wdata,
  output logic [STAT_W-1:0] cfg_rdata,
  input  logic [W-1:0]      func_in,
  output logic [W-1:0]      cut_in,
  input  logic [W-1:0]      cut_out,
  output logic              busy,
  output logic              done,
  output logic              go_nogo
);
  bist_state_e state;
  logic mode_q, start_req;
  logic lfsr_load, lfsr_step, cmp_en, clr_fail, fail;
  logic [W-1:0] pattern;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata[STAT_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= test_mode;
  end

  assign start_req = (test_mode && !mode_q) ||
                     (cfg_wr && cfg_wdata[STAT_START] && test_mode);

  bist_seq #(.NUM_PAT(NUM_PAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .test_mode(test_mode),
    .state(state), .lfsr_load(lfsr_load), .lfsr_step(lfsr_step),
    .cmp_en(cmp_en), .clr_fail(clr_fail)
  );

  bist_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(lfsr_load), .step(lfsr_step), .q(pattern)
  );

  bist_cmp #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(clr_fail), .en(cmp_en),
    .resp(cut_out), .expect_val(pattern), .fail(fail)
  );

  assign cut_in  = test_mode ? pattern : func_in;
  assign busy    = (state == ST_INIT) || (state == ST_APPLY) || (state == ST_CMP);
  assign done    = (state == ST_DONE);
  assign go_nogo = done && !fail;

  always_comb begin
    cfg_rdata             = '0;
    cfg_rdata[STAT_BUSY]  = busy;
    cfg_rdata[STAT_DONE]  = done;
    cfg_rdata[STAT_PASS]  = go_nogo;
  end
endmodule

// File: rtl/bist_ctrl_chk.sv
module bist_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         test_mode,
  input logic [W-1:0] cut_in,
  input logic         busy,
  input logic         done,
  input logic         go_nogo
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R6

  AST_PASS_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    go_nogo |-> done); // R7

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go_nogo) |=> !go_nogo); // R7

  AST_PATTERN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (cut_in != '0)); // R4

  AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || !$past(test_mode))); // R9
endmodule

bind bist_ctrl bist_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .cut_in(cut_in),
  .busy(busy), .done(done), .go_nogo(go_nogo)
);

// File: tb/bist_ctrl_test.sv
module bist_ctrl_test;
  localparam int W = 8;
  localparam int N = 255;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, test_mode, cfg_wr, busy, done, go_nogo, inject;
  logic [3:0] cfg_wdata, cfg_rdata;
  logic [W-1:0] func_in, cut_in, cut_out;

  int checks = 0;
  int errors = 0;
  bit running = 0;

  bist_ctrl uut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .func_in(func_in),
    .cut_in(cut_in), .cut_out(cut_out), .busy(busy), .done(done),
    .go_nogo(go_nogo)
  );

  // Loopback circuit under test with one register stage and an optional fault.
  always_ff @(posedge clk)
    cut_out <= cut_in ^ ((inject && cut_in == 8'h40) ? 8'h01 : 8'h00);

  // Behavioural reference: 0 idle, 1 init, 2 apply, 3 compare, 4 done.
  int m_st, m_cnt;
  logic [W-1:0] m_lf;
  bit m_fail, m_tmq, m_req;
  bit seen [256];
  bit track;

  function automatic logic [W-1:0] next_pat(input logic [W-1:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_lf = 8'h01; m_fail = 0; m_cnt = 0; m_tmq = 0;
    end else begin
      m_req = (test_mode && !m_tmq) || (cfg_wr && cfg_wdata[0] && test_mode);
      case (m_st)
        0, 4: if (m_req) m_st = 1;
        1: if (!test_mode) m_st = 0;
           else begin m_lf = 8'h01; m_cnt = 0; m_fail = 0; m_st = 2; end
        2: m_st = test_mode ? 3 : 0;
        3: if (!test_mode) m_st = 0;
           else begin
             if (cut_out !== m_lf) m_fail = 1;
             m_lf = next_pat(m_lf);
             m_cnt++;
             m_st = (m_cnt == N) ? 4 : 2;
           end
        default: m_st = 0;
      endcase
      m_tmq = test_mode;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      logic [W-1:0] exp_cut;
      bit eb, ed, ep;
      exp_cut = test_mode ? m_lf : func_in;
      eb = (m_st >= 1 && m_st <= 3);
      ed = (m_st == 4);
      ep = ed && !m_fail;
      chk(cut_in === exp_cut, test_mode ? "R3 cut_in" : "R1 cut_in", cut_in, exp_cut);
      chk(busy === eb, "R2 busy", busy, eb);
      chk(done === ed, "R6 done", done, ed);
      chk(go_nogo === ep, "R7 go_nogo", go_nogo, ep);
      chk(cfg_rdata === {ep, ed, eb, 1'b0}, "R8 status", cfg_rdata, {ep, ed, eb, 1'b0});
      if (track && m_st == 2) seen[cut_in] = 1;
    end
  end

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      if (n == 100) begin cfg_wr = 1; cfg_wdata = 4'h1; end   // start while busy: R2 ignored
      else begin cfg_wr = 0; cfg_wdata = 4'h0; end
    end while (!done && n < 2000);
  endtask

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
      func_in = func_in * 8'd37 + 8'd11;
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n, cnt_seen;
    rst_n = 0; test_mode = 0; cfg_wr = 0; cfg_wdata = 0; func_in = 8'h5A; inject = 0; track = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(cfg_rdata === 4'h0 && !busy && !done && !go_nogo, "R8 reset", cfg_rdata, 0);
    chk(cut_in === func_in, "R1 reset passthrough", cut_in, func_in);
    rst_n = 1;
    running = 1;
    cycles(12);                                   // R1 functional patterns

    // Run 1: start by rising mode, clean loopback
    foreach (seen[i]) seen[i] = 0;
    track = 1;
    test_mode = 1;
    wait_done(n);
    track = 0;
    chk(n == 2 * N + 2, "R5 test length", n, 2 * N + 2);
    cnt_seen = 0;
    foreach (seen[i]) if (seen[i]) cnt_seen++;
    chk(cnt_seen == N && !seen[0], "R4 R6 distinct nonzero patterns", cnt_seen, N);
    chk(go_nogo === 1'b1, "R7 pass on clean run", go_nogo, 1);
    cycles(3);
    test_mode = 0;
    cycles(4);
    chk(done === 1'b1 && go_nogo === 1'b1, "R7 verdict held after mode drop", {done, go_nogo}, 3);

    // Run 2: single-bit fault on one pattern
    inject = 1;
    test_mode = 1;
    wait_done(n);
    chk(go_nogo === 1'b0 && done === 1'b1, "R7 fail on mismatch", go_nogo, 0);
    inject = 0;
    cycles(5);

    // Run 3: register start clears the old verdict
    cfg_wr = 1; cfg_wdata = 4'h1;
    wait_done(n);
    chk(go_nogo === 1'b1, "R7 fail cleared by new start", go_nogo, 1);

    // Register start while mode is off is ignored
    test_mode = 0;
    cycles(2);
    cfg_wr = 1; cfg_wdata = 4'h1;
    @(posedge clk); #1; cfg_wr = 0; cfg_wdata = 0;
    @(posedge clk); #1;
    chk(busy === 1'b0, "R2 start ignored when mode off", busy, 0);

    // Abort in the middle of a run
    test_mode = 1;
    cycles(40);
    chk(busy === 1'b1, "R2 busy during run", busy, 1);
    test_mode = 0;
    @(posedge clk); #1;
    chk(busy === 1'b0 && done === 1'b0, "R9 abort", {busy, done}, 0);
    cycles(10);                                   // R1 after abort

    running = 0;
    summary();
  end
endmodule